// File: doc/BRIEF.md
# Character Raster Timing Generator

This block produces the horizontal and vertical timing of a character-based CRT display. It runs one step per character clock and walks a horizontal character counter, a scanline-within-row counter and a 7-bit row counter. From these it derives horizontal sync, vertical sync, display enable, a memory address for the character fetcher and a small status byte that software can poll.

Every limit is checked with an equality compare against a programmable register, never with a magnitude compare. A register that is rewritten below the running count is therefore simply missed. The counter then runs on until it wraps. This behaviour is intended: it lets software rewrite the registers in the middle of a frame to stack several short frames on one physical screen, to suppress sync pulses or to shorten the visible vertical sync. Software reaches the registers through a two-step port. The first write selects a register index and the second write loads that register.

Top module: `crt_raster_core`

## Requirements
- R1: The horizontal counter `hcc_o` counts up by one each clock. In the clock after it equals the line-total register (index 0x00), it returns to 0, so a line lasts total+1 clocks.
- R2: The line end is an equality compare only. If the line total is rewritten below the running count, `hcc_o` keeps counting through 255, wraps to 0, and the next line ends at the new total.
- R3: The row counter `vcc_o` is 7 bits wide. If the row-total register (index 0x03) is rewritten below the current row, `vcc_o` runs on through 127 and wraps to 0. After that, a frame ends after row = row total.
- R4: At each line end, `sl_o` increments until it equals the row-height register (index 0x07). At that point it returns to 0 and the row advances. A row that began with `vcc_o` equal to the row total ends the frame instead.
- R5: After the last row, the number of extra lines given by the adjust register (index 0x04) elapses before the new frame. A frame therefore lasts (rowtotal+1)*(rowheight+1)+adjust lines.
- R6: `vsync_o` rises on the first clock of a row whose `vcc_o` equals the sync-row register (index 0x06). If that row is never reached, there is no vertical sync.
- R7: `vsync_o` stays high for exactly 16 line-end events. These events come from the horizontal counter reaching the line total, whether or not `hsync_o` pulses. A new match while the pulse is already high is ignored.
- R8: `hsync_o` goes high on the clock where `hcc_o` equals the sync-column register (index 0x02) and stays high for HSYNC_W clocks. If that column is never reached, there is no pulse.
- R9: `de_o` is high while `hcc_o` is below the displayed-columns register (index 0x01) and the frame is in its first N rows, where N is the displayed-rows register (index 0x05). In `status_o`, bit 0 = not `de_o`, bit 3 = `vsync_o`, and all other bits are 0.
- R10: At each frame start, the 14-bit start address (index 0x08 high six bits, index 0x09 low eight bits) is latched into the row base. The row base advances by the displayed-columns value at each row step, and `ma_o` = row base + `hcc_o`.
- R11: A write with `wr_sel`=0 loads the index. A write with `wr_sel`=1 loads the indexed register, which takes effect on the next clock. Indices above 0x09 are ignored.
- R12: Under reset, all counters, `hsync_o`, `vsync_o` and `de_o` are 0, `status_o` is 0x01, and the register file holds a configuration that produces no sync pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register port write strobe |
| wr_sel | input | 1 | 0 selects the index, 1 selects data |
| wr_data | input | 8 | Write data |
| hcc_o | output | 8 | Horizontal character counter |
| vcc_o | output | 7 | Row counter |
| sl_o | output | 5 | Scanline within row |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| ma_o | output | 14 | Character memory address |
| status_o | output | 8 | Polled status byte |

## Verification
The baseline is a steady frame of ten-clock lines, two-line rows and two adjust lines. Its line length, sync column, display-enable window, row addresses, frame period and sync spacing confirm the nominal geometry. Setting the adjust count to zero separates the adjust path from the row path through the change in frame length. Moving the sync column past the line total shows that vertical sync length depends on line-end events and not on horizontal pulses. Two mid-stream rewrites, one lowering the line total below the running column and one lowering the row total below the running row, separate equality compares from magnitude compares. They show full-range wraps, a vertical sync reached only during the row wrap, and a short frame once the counters have come back round.

// File: rtl/crt_raster_pkg.sv
package crt_raster_pkg;
  localparam int unsigned HCW = 8;
  localparam int unsigned VCW = 7;
  localparam int unsigned SLW = 5;
  localparam int unsigned MAW = 14;
  localparam int unsigned DW  = 8;

  localparam logic [DW-1:0] RI_HTOT  = 8'h00;
  localparam logic [DW-1:0] RI_HDISP = 8'h01;
  localparam logic [DW-1:0] RI_HSP   = 8'h02;
  localparam logic [DW-1:0] RI_VTOT  = 8'h03;
  localparam logic [DW-1:0] RI_VADJ  = 8'h04;
  localparam logic [DW-1:0] RI_VDISP = 8'h05;
  localparam logic [DW-1:0] RI_VSP   = 8'h06;
  localparam logic [DW-1:0] RI_MAXSL = 8'h07;
  localparam logic [DW-1:0] RI_SA_HI = 8'h08;
  localparam logic [DW-1:0] RI_SA_LO = 8'h09;

  typedef struct packed {
    logic [HCW-1:0] htot;
    logic [HCW-1:0] hdisp;
    logic [HCW-1:0] hsp;
    logic [VCW-1:0] vtot;
    logic [VCW-1:0] vdisp;
    logic [VCW-1:0] vsp;
    logic [SLW-1:0] vadj;
    logic [SLW-1:0] maxsl;
    logic [MAW-1:0] start;
  } crt_cfg_t;

  localparam crt_cfg_t CFG_RST = '{
    htot: '0, hdisp: '0, hsp: '1, vtot: '0, vdisp: '0,
    vsp: '1, vadj: '0, maxsl: '0, start: '0
  };
endpackage

// File: rtl/crt_regfile.sv
module crt_regfile
  import crt_raster_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output crt_cfg_t      cfg_o
);
  logic [DW-1:0] idx_q, idx_n;
  crt_cfg_t      cfg_q, cfg_n;

  always_comb begin
    idx_n = idx_q;
    cfg_n = cfg_q;
    if (wr_en && !wr_sel) begin
      idx_n = wr_data;
    end else if (wr_en && wr_sel) begin
      case (idx_q)
        RI_HTOT:  cfg_n.htot  = wr_data[HCW-1:0];
        RI_HDISP: cfg_n.hdisp = wr_data[HCW-1:0];
        RI_HSP:   cfg_n.hsp   = wr_data[HCW-1:0];
        RI_VTOT:  cfg_n.vtot  = wr_data[VCW-1:0];
        RI_VADJ:  cfg_n.vadj  = wr_data[SLW-1:0];
        RI_VDISP: cfg_n.vdisp = wr_data[VCW-1:0];
        RI_VSP:   cfg_n.vsp   = wr_data[VCW-1:0];
        RI_MAXSL: cfg_n.maxsl = wr_data[SLW-1:0];
        RI_SA_HI: cfg_n.start[MAW-1:DW] = wr_data[MAW-DW-1:0];
        RI_SA_LO: cfg_n.start[DW-1:0]   = wr_data;
        default:  cfg_n = cfg_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cfg_q <= CFG_RST;
    end else begin
      idx_q <= idx_n;
      cfg_q <= cfg_n;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/crt_hgen.sv
module crt_hgen
  import crt_raster_pkg::*;
#(
  parameter int unsigned HSYNC_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HCW-1:0] htot,
  input  logic [HCW-1:0] hdisp,
  input  logic [HCW-1:0] hsp,
  output logic [HCW-1:0] hcc_o,
  output logic           h_end_o,
  output logic           h_act_o,
  output logic           hsync_o
);
  localparam int unsigned    HSC_W    = (HSYNC_W > 1) ? $clog2(HSYNC_W) : 1;
  localparam logic [HSC_W-1:0] HSC_LAST = HSC_W'(HSYNC_W - 1);
  localparam logic [HSC_W-1:0] HSC_ONE  = HSC_W'(1);
  localparam logic [HCW-1:0]   H_ONE    = HCW'(1);

  logic [HCW-1:0]   hcc_q, hcc_n;
  logic             hact_q, hact_n;
  logic             hs_q, hs_n;
  logic [HSC_W-1:0] hsc_q, hsc_n;
  logic             h_end;

  assign h_end = (hcc_q == htot);

  always_comb begin
    hcc_n  = h_end ? '0 : hcc_q + H_ONE;
    hact_n = hact_q;
    if (h_end) hact_n = 1'b1;
    if (hcc_n == hdisp) hact_n = 1'b0;
    hs_n  = hs_q;
    hsc_n = hsc_q;
    if (hs_q) begin
      if (hsc_q == HSC_LAST) hs_n = 1'b0;
      else hsc_n = hsc_q + HSC_ONE;
    end else if (hcc_n == hsp) begin
      hs_n  = 1'b1;
      hsc_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcc_q  <= '0;
      hact_q <= 1'b0;
      hs_q   <= 1'b0;
      hsc_q  <= '0;
    end else begin
      hcc_q  <= hcc_n;
      hact_q <= hact_n;
      hs_q   <= hs_n;
      hsc_q  <= hsc_n;
    end
  end

  assign hcc_o   = hcc_q;
  assign h_end_o = h_end;
  assign h_act_o = hact_q;
  assign hsync_o = hs_q;
endmodule

// File: rtl/crt_vgen.sv
module crt_vgen
  import crt_raster_pkg::*;
#(
  parameter int unsigned VSYNC_LINES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_end,
  input  logic [HCW-1:0] hcc,
  input  crt_cfg_t       cfg,
  output logic [VCW-1:0] vcc_o,
  output logic [SLW-1:0] sl_o,
  output logic           v_act_o,
  output logic           vsync_o,
  output logic [MAW-1:0] row_ma_o
);
  localparam int unsigned      VSC_W   = (VSYNC_LINES > 1) ? $clog2(VSYNC_LINES) : 1;
  localparam logic [VSC_W-1:0] VSC_END = VSC_W'(VSYNC_LINES - 1);
  localparam logic [VSC_W-1:0] VSC_ONE = VSC_W'(1);
  localparam logic [HCW-1:0]   H_TWO   = HCW'(2);
  localparam logic [VCW-1:0]   V_ONE   = VCW'(1);
  localparam logic [SLW-1:0]   S_ONE   = SLW'(1);

  logic [VCW-1:0]   vcc_q, vcc_n;
  logic [SLW-1:0]   sl_q, sl_n;
  logic             last_q, last_n, row_last;
  logic             adj_q, adj_n;
  logic [SLW-1:0]   adjc_q, adjc_n;
  logic             vact_q, vact_n;
  logic             vs_q, vs_n;
  logic [VSC_W-1:0] vsc_q, vsc_n;
  logic [MAW-1:0]   rma_q, rma_n;
  logic             frame_go, row_go;

  // last-row flag is sampled while the column is still in the first two
  assign row_last = last_q |
                    ((sl_q == '0) && !adj_q && (hcc < H_TWO) && (vcc_q == cfg.vtot));

  always_comb begin
    vcc_n    = vcc_q;
    sl_n     = sl_q;
    last_n   = row_last;
    adj_n    = adj_q;
    adjc_n   = adjc_q;
    vact_n   = vact_q;
    vs_n     = vs_q;
    vsc_n    = vsc_q;
    rma_n    = rma_q;
    frame_go = 1'b0;
    row_go   = 1'b0;
    if (h_end) begin
      if (adj_q) begin
        if (adjc_q == cfg.vadj) frame_go = 1'b1;
        else adjc_n = adjc_q + S_ONE;
      end else if (sl_q == cfg.maxsl) begin
        sl_n = '0;
        if (row_last) begin
          last_n = 1'b0;
          if (cfg.vadj == '0) frame_go = 1'b1;
          else begin
            adj_n  = 1'b1;
            adjc_n = S_ONE;
          end
        end else begin
          row_go = 1'b1;
        end
      end else begin
        sl_n = sl_q + S_ONE;
      end

      if (frame_go) begin
        vcc_n  = '0;
        sl_n   = '0;
        adj_n  = 1'b0;
        rma_n  = cfg.start;
        vact_n = (cfg.vdisp != '0);
      end else if (row_go) begin
        vcc_n = vcc_q + V_ONE;
        rma_n = rma_q + {{(MAW-HCW){1'b0}}, cfg.hdisp};
        if (vcc_n == cfg.vdisp) vact_n = 1'b0;
      end

      if (vs_q) begin
        if (vsc_q == VSC_END) vs_n = 1'b0;
        else vsc_n = vsc_q + VSC_ONE;
      end else if ((frame_go || row_go) && (vcc_n == cfg.vsp)) begin
        vs_n  = 1'b1;
        vsc_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcc_q  <= '0;
      sl_q   <= '0;
      last_q <= 1'b0;
      adj_q  <= 1'b0;
      adjc_q <= '0;
      vact_q <= 1'b0;
      vs_q   <= 1'b0;
      vsc_q  <= '0;
      rma_q  <= '0;
    end else begin
      vcc_q  <= vcc_n;
      sl_q   <= sl_n;
      last_q <= last_n;
      adj_q  <= adj_n;
      adjc_q <= adjc_n;
      vact_q <= vact_n;
      vs_q   <= vs_n;
      vsc_q  <= vsc_n;
      rma_q  <= rma_n;
    end
  end

  assign vcc_o    = vcc_q;
  assign sl_o     = sl_q;
  assign v_act_o  = vact_q;
  assign vsync_o  = vs_q;
  assign row_ma_o = rma_q;
endmodule

// File: rtl/crt_raster_core.sv
module crt_raster_core
  import crt_raster_pkg::*;
#(
  parameter int unsigned HSYNC_W     = 4,
  parameter int unsigned VSYNC_LINES = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [DW-1:0]  wr_data,
  output logic [HCW-1:0] hcc_o,
  output logic [VCW-1:0] vcc_o,
  output logic [SLW-1:0] sl_o,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic [MAW-1:0] ma_o,
  output logic [7:0]     status_o
);
  crt_cfg_t       cfg;
  logic           h_end, h_act, v_act;
  logic [MAW-1:0] row_ma;

  crt_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cfg_o(cfg)
  );

  crt_hgen #(.HSYNC_W(HSYNC_W)) u_hgen (
    .clk(clk), .rst_n(rst_n), .htot(cfg.htot), .hdisp(cfg.hdisp),
    .hsp(cfg.hsp), .hcc_o(hcc_o), .h_end_o(h_end), .h_act_o(h_act),
    .hsync_o(hsync_o)
  );

  crt_vgen #(.VSYNC_LINES(VSYNC_LINES)) u_vgen (
    .clk(clk), .rst_n(rst_n), .h_end(h_end), .hcc(hcc_o), .cfg(cfg),
    .vcc_o(vcc_o), .sl_o(sl_o), .v_act_o(v_act), .vsync_o(vsync_o),
    .row_ma_o(row_ma)
  );

  assign de_o     = h_act & v_act;
  assign ma_o     = row_ma + {{(MAW-HCW){1'b0}}, hcc_o};
  assign status_o = {4'b0000, vsync_o, 2'b00, ~de_o};
endmodule

// File: rtl/crt_raster_chk.sv
module crt_raster_chk
  import crt_raster_pkg::*;
#(
  parameter int unsigned VSYNC_LINES = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [HCW-1:0] hcc,
  input logic [VCW-1:0] vcc,
  input logic [SLW-1:0] sl,
  input logic           hsync,
  input logic           vsync,
  input logic           h_end,
  input logic [HCW-1:0] hsp,
  input logic [VCW-1:0] vsp
);
  localparam int unsigned EVW = $clog2(VSYNC_LINES) + 2;
  logic [EVW-1:0] vs_ev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_ev_q <= '0;
    else if (!vsync) vs_ev_q <= '0;
    else if (h_end) vs_ev_q <= vs_ev_q + EVW'(1);
  end

  assert_hcc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hcc != '0) |-> (hcc == HCW'($past(hcc) + HCW'(1))));

  assert_vcc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc != $past(vcc)) |-> ((vcc == '0) || (vcc == VCW'($past(vcc) + VCW'(1)))));

  assert_sl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(h_end) |-> $stable(sl));

  assert_vs_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> ((vcc == $past(vsp)) && (sl == '0)));

  assert_vs_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> (vs_ev_q < EVW'(VSYNC_LINES)));

  assert_hs_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> (hcc == $past(hsp)));
endmodule

bind crt_raster_core crt_raster_chk #(.VSYNC_LINES(VSYNC_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .hcc(hcc_o), .vcc(vcc_o), .sl(sl_o),
  .hsync(hsync_o), .vsync(vsync_o), .h_end(h_end),
  .hsp(cfg.hsp), .vsp(cfg.vsp)
);

// File: tb/crt_raster_core_tb.sv
module crt_raster_core_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0]  hcc_o;
  logic [6:0]  vcc_o;
  logic [4:0]  sl_o;
  logic        hsync_o, vsync_o, de_o;
  logic [13:0] ma_o;
  logic [7:0]  status_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  crt_raster_core u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hcc_o(hcc_o), .vcc_o(vcc_o), .sl_o(sl_o), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .de_o(de_o), .ma_o(ma_o), .status_o(status_o)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_index_now(int i);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = i[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_data_now(int v);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = v[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_reg(int i, int v);
    @(negedge clk);
    set_index_now(i);
    write_data_now(v);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_hcc(int v, output bit found);
    found = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (int'(hcc_o) == v) begin found = 1'b1; break; end
    end
  endtask

  task automatic wait_vcc(int v);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (int'(vcc_o) == v) break;
    end
  endtask

  task automatic wait_frame();
    int p;
    p = int'(vcc_o);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (p != 0 && vcc_o == 7'd0) break;
      p = int'(vcc_o);
    end
  endtask

  task automatic line_len(output int n);
    bit f;
    wait_hcc(0, f);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (hcc_o != 8'd0 && n < 1000);
  endtask

  task automatic frame_period(output int n);
    int p;
    wait_frame();
    n = 0;
    p = int'(vcc_o);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      n++;
      if (p != 0 && vcc_o == 7'd0) break;
      p = int'(vcc_o);
    end
  endtask

  task automatic vs_measure(output int hi, output int lo, output int v_at,
                            output int s_at, output int h_at, output int st_bad);
    bit p;
    hi = 0; lo = 0; st_bad = 0; v_at = -1; s_at = -1; h_at = -1;
    p = vsync_o;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (!p && vsync_o) break;
      p = vsync_o;
    end
    v_at = int'(vcc_o); s_at = int'(sl_o); h_at = int'(hcc_o);
    while (vsync_o && hi < 5000) begin
      hi++;
      if (status_o[3] != 1'b1) st_bad++;
      @(negedge clk);
    end
    while (!vsync_o && lo < 5000) begin
      lo++;
      if (status_o[3] != 1'b0) st_bad++;
      @(negedge clk);
    end
  endtask

  task automatic setup_normal();
    wr_reg(0, 9);  wr_reg(1, 6);  wr_reg(2, 7);  wr_reg(3, 3);
    wr_reg(4, 2);  wr_reg(5, 2);  wr_reg(6, 3);  wr_reg(7, 1);
    wr_reg(8, 8'h01); wr_reg(9, 8'h00);
    idle(300);
  endtask

  task automatic t_reset();
    chk("R12 hcc in reset", int'(hcc_o), 0);
    chk("R12 status in reset", int'(status_o), 1);
    @(negedge clk); rst_n = 1'b1;
    idle(20);
    chk("R12 hcc after reset", int'(hcc_o), 0);
    chk("R12 vcc after reset", int'(vcc_o), 0);
    chk("R12 sl after reset", int'(sl_o), 0);
    chk("R12 hsync after reset", int'(hsync_o), 0);
    chk("R12 vsync after reset", int'(vsync_o), 0);
    chk("R12 de after reset", int'(de_o), 0);
    chk("R12 ma after reset", int'(ma_o), 0);
  endtask

  task automatic t_line();
    int n, hs_n, hs_first, de_n, st_bad;
    bit f;
    line_len(n);
    chk("R1 line length", n, 10);
    wait_hcc(3, f);
    hs_n = 0; hs_first = -1;
    for (int k = 0; k < 10; k++) begin
      if (hsync_o) begin
        if (hs_first < 0) hs_first = int'(hcc_o);
        hs_n++;
      end
      @(negedge clk);
    end
    chk("R8 hsync width", hs_n, 4);
    chk("R8 hsync start column", hs_first, 7);
    wait_frame();
    de_n = 0; st_bad = 0;
    for (int k = 0; k < 10; k++) begin
      if (de_o) de_n++;
      if (status_o[0] == de_o) st_bad++;
      if ((status_o & 8'hF6) != 8'h00) st_bad++;
      @(negedge clk);
    end
    chk("R9 de columns in displayed row", de_n, 6);
    chk("R9 status bit0 and spare bits", st_bad, 0);
    wait_vcc(2);
    de_n = 0;
    for (int k = 0; k < 10; k++) begin
      if (de_o) de_n++;
      @(negedge clk);
    end
    chk("R9 de off past displayed rows", de_n, 0);
  endtask

  task automatic t_frame();
    int n, smax;
    wait_frame();
    chk("R10 ma at frame start", int'(ma_o), 'h100);
    chk("R4 sl at frame start", int'(sl_o), 0);
    smax = 0;
    frame_period(n);
    chk("R5 frame period with adjust 2", n, 100);
    wait_vcc(1);
    chk("R10 ma at row 1", int'(ma_o), 'h106);
    for (int k = 0; k < 20; k++) begin
      if (int'(sl_o) > smax) smax = int'(sl_o);
      @(negedge clk);
    end
    chk("R4 scanlines per row", smax, 1);
  endtask

  task automatic t_vsync();
    int hi, lo, v, s, h, sb;
    vs_measure(hi, lo, v, s, h, sb);
    chk("R6 vsync row", v, 3);
    chk("R6 vsync scanline", s, 0);
    chk("R6 vsync column", h, 0);
    chk("R7 vsync high clocks", hi, 160);
    chk("R7 vsync low clocks", lo, 40);
    chk("R9 status bit3 follows vsync", sb, 0);
  endtask

  task automatic t_nohs();
    int n, hi, lo, v, s, h, sb;
    wr_reg(2, 200);
    idle(50);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      if (hsync_o) n++;
      @(negedge clk);
    end
    chk("R8 no hsync when column unreachable", n, 0);
    vs_measure(hi, lo, v, s, h, sb);
    chk("R7 vsync length without hsync", hi, 160);
    wr_reg(2, 7);
    idle(50);
  endtask

  task automatic t_vadj0();
    int n;
    wr_reg(4, 0);
    idle(100);
    frame_period(n);
    chk("R5 frame period with adjust 0", n, 80);
    wr_reg(4, 2);
    idle(100);
  endtask

  task automatic t_index();
    int n;
    wr_reg(12, 0);
    wr_reg(8'h83, 0);
    idle(20);
    line_len(n);
    chk("R11 unused index ignored, line", n, 10);
    frame_period(n);
    chk("R11 unused index ignored, frame", n, 100);
  endtask

  task automatic t_hover();
    int n;
    bit f;
    @(negedge clk);
    set_index_now(0);
    wait_hcc(7, f);
    write_data_now(5);
    wait_hcc(255, f);
    chk("R2 hcc runs past lowered total to 255", int'(f), 1);
    line_len(n);
    chk("R2 line length after wrap", n, 6);
    chk("R11 new total in effect", int'(hcc_o), 0);
    wr_reg(0, 9);
    idle(50);
  endtask

  task automatic t_vover();
    int n, vs_row, vsn;
    bit seen, pv;
    wr_reg(7, 0); wr_reg(4, 0); wr_reg(6, 100); wr_reg(5, 10); wr_reg(3, 20);
    idle(50);
    @(negedge clk);
    set_index_now(3);
    wait_vcc(10);
    write_data_now(3);
    seen = 1'b0; vs_row = -1; pv = vsync_o;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (vcc_o == 7'd127) seen = 1'b1;
      if (!pv && vsync_o) vs_row = int'(vcc_o);
      pv = vsync_o;
      if (seen && vcc_o == 7'd0) break;
    end
    chk("R3 vcc wraps through 127", int'(seen), 1);
    chk("R6 vsync reached during wrap", vs_row, 100);
    frame_period(n);
    chk("R3 short frame after wrap", n, 40);
    vsn = 0;
    for (int k = 0; k < 500; k++) begin
      if (vsync_o) vsn++;
      @(negedge clk);
    end
    chk("R6 no vsync when sync row above total", vsn, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset();
    setup_normal();
    t_line();
    t_frame();
    t_vsync();
    t_nohs();
    t_vadj0();
    t_index();
    t_hover();
    t_vover();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule